// File: doc/BRIEF.md
# Read-Snooping Multicart Bank Mapper

This block switches ROM banks on a game console multicart. It watches the CPU bus at every cycle strobe. When an access falls in one of three windows at the top of the address map, the block copies the byte on the data bus into the matching control register. Reads load a register as well as writes, so a game can switch banks by reading a byte from a table of bank values kept in ROM.

From its registers the block drives several outputs. It drives the upper PRG and CHR ROM address lines and the enables for two ROM pairs. It drives the nametable A10 line, which sets mirroring, and a two-bit output for the lockout-defeat drive.

A mode bit sets the slice size. In mode 0 the outer block selects a 32 KiB slice. In mode 1 it selects a 64 KiB slice, and the inner register then picks the PRG page and the upper CHR bit. Once any bank bit of the outer register is nonzero, the outer register and the lockout register are frozen until reset.

Top module: `snoop_bank_mapper`

## Requirements
- R1: After reset every register is zero, so all outputs are as follows. `prg_bank_o` is 0, `chr_bank_o` is 0 and `lockout_o` is 0. Mirroring is vertical, ROM pair 1 is the selected pair, and the block is unlocked.
- R2: A register loads `cpu_data_i` only on a falling edge of `m2_i` while `cpu_addr_i` is in its window. This works for reads (`cpu_rw_i`=1) and for writes. The windows are: outer $FF80-$FF9F, lockout $FFC0-$FFDF, inner $FFE8-$FFF7. Any other address, or `m2_i` held high with no falling edge, changes nothing.
- R3: The outer register bits are: bit 7 mirroring, bit 6 mode, bit 5 pair select, bit 4 disable for pair 2, bits 3..1 block, bit 0 block LSB. In mode 0, `prg_bank_o` = {block, block LSB}, and inner bit 0 has no effect.
- R4: In mode 1, `prg_bank_o` = {block, inner bit 0}, and outer bit 0 has no effect.
- R5: `chr_bank_o` = {block, x, inner bits 5..4}. In mode 0, x is outer bit 0. In mode 1, x is inner bit 6.
- R6: While outer bits 5..0 are nonzero, accesses in the outer and lockout windows are ignored until reset. The inner register still loads.
- R7: Outer bit 7 = 0 makes `ciram_a10_o` follow `ppu_a10_i`. Bit 7 = 1 makes it follow `ppu_a11_i`. Bits 7 and 6 alone never lock the block.
- R8: `prg_ce_o[0]` enables pair 1 when the pair select is 0. `prg_ce_o[1]` enables pair 2 when the pair select is 1 and the pair-2 disable is 0. Both enables are active only for a CPU read with `cpu_addr_i[15]`=1.
- R9: `chr_ce_o` picks its pair the same way as `prg_ce_o`, and is active only while `ppu_a13_i`=0.
- R10: `lockout_o` holds data bits 1..0 from the last load of the lockout window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m2_i | input | 1 | CPU cycle strobe |
| cpu_addr_i | input | 16 | CPU address bus |
| cpu_data_i | input | 8 | CPU data bus, observed |
| cpu_rw_i | input | 1 | 1 = read, 0 = write |
| ppu_a13_i | input | 1 | PPU address bit 13 |
| ppu_a11_i | input | 1 | PPU address bit 11 |
| ppu_a10_i | input | 1 | PPU address bit 10 |
| prg_bank_o | output | 4 | PRG ROM A18..A15 |
| chr_bank_o | output | 6 | CHR ROM A18..A13 |
| prg_ce_o | output | 2 | PRG enable per ROM pair |
| chr_ce_o | output | 2 | CHR enable per ROM pair |
| ciram_a10_o | output | 1 | Nametable A10 |
| lockout_o | output | 2 | Lockout-defeat drive |

## Verification
Two things can happen on the same strobe edge. An access that writes nonzero bank bits into the outer register also sets the lock, and that lock must block the very next outer or lockout access but never the inner register. The bench provokes this in several ways. It writes a bank value and then tries to overwrite the outer and lockout registers. It reloads the inner register after the lock has closed. It also shows that mirror or mode bits on their own leave the outer register free to change. Each case is judged by the bank, drive and mirroring outputs the following cycle.

// File: rtl/snoop_mapper_pkg.sv
package snoop_mapper_pkg;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int BLOCK_W    = 3;
  localparam int CHR_LO_W   = 2;
  localparam int DRIVE_W    = 2;
  localparam int NUM_PAIRS  = 2;
  localparam int PRG_BANK_W = BLOCK_W + 1;
  localparam int CHR_BANK_W = BLOCK_W + 1 + CHR_LO_W;

  localparam int NUM_WIN  = 3;
  localparam int WIN_OUTER = 0;
  localparam int WIN_DRIVE = 1;
  localparam int WIN_INNER = 2;
  localparam logic [ADDR_W-1:0] WIN_LO [NUM_WIN] = '{16'hFF80, 16'hFFC0, 16'hFFE8};
  localparam logic [ADDR_W-1:0] WIN_HI [NUM_WIN] = '{16'hFF9F, 16'hFFDF, 16'hFFF7};

  typedef struct packed {
    logic               mirror_h;
    logic               mode_wide;
    logic               pair_sel;
    logic               pair_hi_off;
    logic [BLOCK_W-1:0] block;
    logic               block_lsb;
  } outer_t;

  typedef struct packed {
    logic                chr_hi;
    logic [CHR_LO_W-1:0] chr_lo;
    logic                prg_pg;
  } inner_t;
endpackage

// File: rtl/snoop_win_decode.sv
module snoop_win_decode
  import snoop_mapper_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_WIN-1:0] hit_o
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign hit_o[w] = (addr_i >= WIN_LO[w]) && (addr_i <= WIN_HI[w]);
  end

  AST_ONE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o)); // R2
endmodule

// File: rtl/snoop_ctrl_regs.sv
module snoop_ctrl_regs
  import snoop_mapper_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               m2_i,
  input  logic [NUM_WIN-1:0] hit_i,
  input  logic [DATA_W-1:0]  data_i,
  output outer_t             outer_o,
  output inner_t             inner_o,
  output logic [DRIVE_W-1:0] drive_o
);
  logic   m2_q;
  logic   cap;
  logic   locked;
  outer_t outer_q;
  inner_t inner_q;
  logic [DRIVE_W-1:0] drive_q;

  // capture on strobe fall; address/data still valid at this sample
  assign cap    = m2_q & ~m2_i;
  assign locked = outer_q.pair_sel | outer_q.pair_hi_off | (|outer_q.block) | outer_q.block_lsb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m2_q <= 1'b0;
    else         m2_q <= m2_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outer_q <= '0;
      drive_q <= '0;
    end else if (cap && !locked) begin
      if (hit_i[WIN_OUTER]) outer_q <= outer_t'(data_i);
      if (hit_i[WIN_DRIVE]) drive_q <= data_i[DRIVE_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inner_q <= '0;
    end else if (cap && hit_i[WIN_INNER]) begin
      inner_q.chr_hi <= data_i[6];
      inner_q.chr_lo <= data_i[5:4];
      inner_q.prg_pg <= data_i[0];
    end
  end

  assign outer_o = outer_q;
  assign inner_o = inner_q;
  assign drive_o = drive_q;

  AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> $stable(outer_q)); // R6
  AST_DRIVE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> $stable(drive_q)); // R6
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(m2_q && !m2_i) |=> ($stable(outer_q) && $stable(inner_q) && $stable(drive_q))); // R2
endmodule

// File: rtl/snoop_bank_out.sv
module snoop_bank_out
  import snoop_mapper_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  outer_t                outer_i,
  input  inner_t                inner_i,
  input  logic                  cpu_a15_i,
  input  logic                  cpu_rw_i,
  input  logic                  ppu_a13_i,
  input  logic                  ppu_a11_i,
  input  logic                  ppu_a10_i,
  output logic [PRG_BANK_W-1:0] prg_bank_o,
  output logic [CHR_BANK_W-1:0] chr_bank_o,
  output logic [NUM_PAIRS-1:0]  prg_ce_o,
  output logic [NUM_PAIRS-1:0]  chr_ce_o,
  output logic                  ciram_a10_o
);
  logic [NUM_PAIRS-1:0] pair_en;
  logic prg_win, chr_win, mid_bit, prg_lsb;

  always_comb begin
    prg_lsb = outer_i.mode_wide ? inner_i.prg_pg : outer_i.block_lsb;
    mid_bit = outer_i.mode_wide ? inner_i.chr_hi : outer_i.block_lsb;
  end

  assign prg_bank_o  = {outer_i.block, prg_lsb};
  assign chr_bank_o  = {outer_i.block, mid_bit, inner_i.chr_lo};
  assign ciram_a10_o = outer_i.mirror_h ? ppu_a11_i : ppu_a10_i;

  assign prg_win = cpu_a15_i & cpu_rw_i;
  assign chr_win = ~ppu_a13_i;

  // pair 0 on low select; upper pairs also need the disable bit clear
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    if (p == 0) begin : g_lo
      assign pair_en[p] = ~outer_i.pair_sel;
    end else begin : g_hi
      assign pair_en[p] = outer_i.pair_sel & ~outer_i.pair_hi_off;
    end
    assign prg_ce_o[p] = pair_en[p] & prg_win;
    assign chr_ce_o[p] = pair_en[p] & chr_win;
  end

  AST_PRG_CE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(prg_ce_o)); // R8
  AST_PRG_CE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|prg_ce_o) |-> (cpu_a15_i && cpu_rw_i)); // R8
  AST_CHR_CE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|chr_ce_o) |-> !ppu_a13_i); // R9
  AST_HI_PAIR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outer_i.pair_hi_off |-> (!prg_ce_o[1] && !chr_ce_o[1])); // R8
endmodule

// File: rtl/snoop_bank_mapper.sv
module snoop_bank_mapper
  import snoop_mapper_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  m2_i,
  input  logic [ADDR_W-1:0]     cpu_addr_i,
  input  logic [DATA_W-1:0]     cpu_data_i,
  input  logic                  cpu_rw_i,
  input  logic                  ppu_a13_i,
  input  logic                  ppu_a11_i,
  input  logic                  ppu_a10_i,
  output logic [PRG_BANK_W-1:0] prg_bank_o,
  output logic [CHR_BANK_W-1:0] chr_bank_o,
  output logic [NUM_PAIRS-1:0]  prg_ce_o,
  output logic [NUM_PAIRS-1:0]  chr_ce_o,
  output logic                  ciram_a10_o,
  output logic [DRIVE_W-1:0]    lockout_o
);
  logic [NUM_WIN-1:0] hit;
  outer_t outer;
  inner_t inner;

  snoop_win_decode u_decode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (cpu_addr_i),
    .hit_o  (hit)
  );

  snoop_ctrl_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .m2_i    (m2_i),
    .hit_i   (hit),
    .data_i  (cpu_data_i),
    .outer_o (outer),
    .inner_o (inner),
    .drive_o (lockout_o)
  );

  snoop_bank_out u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .outer_i     (outer),
    .inner_i     (inner),
    .cpu_a15_i   (cpu_addr_i[ADDR_W-1]),
    .cpu_rw_i    (cpu_rw_i),
    .ppu_a13_i   (ppu_a13_i),
    .ppu_a11_i   (ppu_a11_i),
    .ppu_a10_i   (ppu_a10_i),
    .prg_bank_o  (prg_bank_o),
    .chr_bank_o  (chr_bank_o),
    .prg_ce_o    (prg_ce_o),
    .chr_ce_o    (chr_ce_o),
    .ciram_a10_o (ciram_a10_o)
  );
endmodule

// File: tb/snoop_bank_mapper_tb.sv
module snoop_bank_mapper_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m2 = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  data = 8'h00;
  logic rw = 1'b1;
  logic a13 = 1'b0, a11 = 1'b1, a10 = 1'b0;
  logic [3:0] prg_bank;
  logic [5:0] chr_bank;
  logic [1:0] prg_ce, chr_ce, lockout;
  logic ciram;
  int n_tests = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  snoop_bank_mapper u_dut (
    .clk_i(clk), .rst_ni(rst_n), .m2_i(m2), .cpu_addr_i(addr), .cpu_data_i(data),
    .cpu_rw_i(rw), .ppu_a13_i(a13), .ppu_a11_i(a11), .ppu_a10_i(a10),
    .prg_bank_o(prg_bank), .chr_bank_o(chr_bank), .prg_ce_o(prg_ce),
    .chr_ce_o(chr_ce), .ciram_a10_o(ciram), .lockout_o(lockout)
  );

  typedef struct packed {
    logic        rst;
    logic        rd;
    logic [15:0] a;
    logic [7:0]  d;
    logic [3:0]  prg;
    logic [5:0]  chr;
    logic [1:0]  lk;
    logic        mir;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 16'hFFE8, 8'h71, 4'd1 - 4'd1, 6'd3,  2'd0, 1'b0}, // R2 R5 write inner, mode 0
    '{1'b0, 1'b1, 16'hFF80, 8'h40, 4'd1,  6'd7,  2'd0, 1'b0}, // R4 R5 read loads mode 1
    '{1'b0, 1'b1, 16'hFFC0, 8'h03, 4'd1,  6'd7,  2'd3, 1'b0}, // R10
    '{1'b0, 1'b0, 16'hFF9F, 8'hC0, 4'd1,  6'd7,  2'd3, 1'b1}, // R7 mirror only, no lock
    '{1'b0, 1'b1, 16'hFFA0, 8'hFF, 4'd1,  6'd7,  2'd3, 1'b1}, // R2 gap
    '{1'b0, 1'b1, 16'hFFE0, 8'h00, 4'd1,  6'd7,  2'd3, 1'b1}, // R2 gap below inner
    '{1'b0, 1'b1, 16'hFFF8, 8'h00, 4'd1,  6'd7,  2'd3, 1'b1}, // R2 above inner
    '{1'b0, 1'b0, 16'hFF85, 8'h4A, 4'd11, 6'd47, 2'd3, 1'b0}, // R4 R5 lock closes
    '{1'b0, 1'b1, 16'hFFC8, 8'h00, 4'd11, 6'd47, 2'd3, 1'b0}, // R6 drive locked
    '{1'b0, 1'b0, 16'hFF80, 8'h00, 4'd11, 6'd47, 2'd3, 1'b0}, // R6 outer locked
    '{1'b0, 1'b1, 16'hFFF7, 8'h20, 4'd10, 6'd42, 2'd3, 1'b0}, // R6 inner still loads
    '{1'b1, 1'b1, 16'hFF90, 8'h0A, 4'd10, 6'd40, 2'd0, 1'b0}, // R3 mode 0
    '{1'b0, 1'b1, 16'hFFF0, 8'h7F, 4'd10, 6'd43, 2'd0, 1'b0}  // R3 R5 P and c ignored
  };

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m2 = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic rd);
    @(negedge clk);
    addr = a; data = d; rw = rd; m2 = 1'b1;
    @(negedge clk);
    m2 = 1'b0;
    @(negedge clk);
    addr = 16'h0000; rw = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    a13 = 1'b0; a11 = 1'b1; a10 = 1'b0;
    addr = 16'h8000; rw = 1'b1;
    #1;
    check("R1 prg", prg_bank, 0);
    check("R1 chr", chr_bank, 0);
    check("R1 lockout", lockout, 0);
    check("R1 mirror vertical", ciram, 0);
    check("R1 prg_ce pair1", prg_ce, 1);
    check("R1 chr_ce pair1", chr_ce, 1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rst) do_reset();
      bus(VEC[i].a, VEC[i].d, VEC[i].rd);
      a11 = 1'b1; a10 = 1'b0;
      #1;
      check($sformatf("R3/R4 vec%0d prg", i), prg_bank, VEC[i].prg);
      check($sformatf("R5 vec%0d chr", i), chr_bank, VEC[i].chr);
      check($sformatf("R10 vec%0d lockout", i), lockout, VEC[i].lk);
      check($sformatf("R7 vec%0d mirror", i), ciram, VEC[i].mir);
    end

    // R2: strobe held high, no falling edge -> no load
    do_reset();
    @(negedge clk);
    addr = 16'hFFE8; data = 8'h71; rw = 1'b1; m2 = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 no fall", chr_bank, 0);
    m2 = 1'b0;
    @(negedge clk);
    check("R2 fall loads", chr_bank, 3);

    // R8 R9 pair selection
    do_reset();
    bus(16'hFF80, 8'h20, 1'b1);
    addr = 16'h8000; rw = 1'b1; a13 = 1'b0; #1;
    check("R8 Q=1 prg_ce", prg_ce, 2);
    check("R9 Q=1 chr_ce", chr_ce, 2);
    do_reset();
    bus(16'hFF80, 8'h30, 1'b1);
    addr = 16'hFFFF; rw = 1'b1; #1;
    check("R8 pair2 disabled prg", prg_ce, 0);
    check("R9 pair2 disabled chr", chr_ce, 0);
    do_reset();
    bus(16'hFF80, 8'h10, 1'b1);
    addr = 16'h8000; rw = 1'b1; #1;
    check("R8 q only keeps pair1", prg_ce, 1);
    rw = 1'b0; #1;
    check("R8 write no prg_ce", prg_ce, 0);
    addr = 16'h7FFF; rw = 1'b1; #1;
    check("R8 below 8000 no prg_ce", prg_ce, 0);
    a13 = 1'b1; #1;
    check("R9 a13 high no chr_ce", chr_ce, 0);
    a13 = 1'b0;

    // R7 mirroring follows selected PPU line; mirror bit alone leaves outer open
    do_reset();
    bus(16'hFF80, 8'h80, 1'b0);
    a10 = 1'b1; a11 = 1'b0; #1;
    check("R7 horiz a11=0", ciram, 0);
    a10 = 1'b0; a11 = 1'b1; #1;
    check("R7 horiz a11=1", ciram, 1);
    bus(16'hFF88, 8'h00, 1'b1);
    a10 = 1'b1; a11 = 1'b0; #1;
    check("R7 R6 back to vertical a10=1", ciram, 1);
    a10 = 1'b0; a11 = 1'b1; #1;
    check("R7 vertical a10=0", ciram, 0);

    // R6 lock via pair-select bit only blocks drive register
    do_reset();
    bus(16'hFF80, 8'h20, 1'b1);
    bus(16'hFFD8, 8'h02, 1'b1);
    #1;
    check("R6 drive blocked by Q lock", lockout, 0);
    do_reset();
    #1;
    check("R1 R6 reset unlocks", lockout, 0);
    bus(16'hFFDF, 8'hFE, 1'b0);
    #1;
    check("R10 drive bits 1..0", lockout, 2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule